// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous read controller for an asynchronous parallel ROM that supports fast page reads. A client hands it a start address, an item count and a byte/word organisation flag. The controller then walks through the requested items one by one and returns each one with a single-cycle valid strobe. On the memory side it drives the address bus, active-low chip and output enables and the organisation select. It captures the data bus after a wait that is set by parameters in clock cycles.

The ROM answers quickly only while the chip stays enabled and the address bits above the page offset do not change. For that reason the controller keeps chip enable low for the whole burst. It applies the long random-access wait to the first item and to every item that opens a new page, and the short page wait to every other item. A page is 8 words in word mode and 16 bytes in byte mode. In byte mode the most significant data pin turns into an output and carries the lowest byte address bit, and the returned byte is zero-extended to the full response width. When a burst ends, both enables go high and the controller holds off new requests until the ROM outputs have had time to float.

Top module: `prom_page_reader`

## Requirements
- R1: Out of reset and whenever idle, `reqReady` is 1, `romCeN` and `romOeN` are both 1 and `rspValid` is 0.
- R2: A request is taken only on a clock edge where `reqValid` and `reqReady` are both 1. On the next cycle `romCeN` and `romOeN` are 0, `romAddr` shows the first address, and `reqReady` stays 0 until the burst and its recovery are over.
- R3: The first item of a burst is captured after max(random wait, output-enable wait) cycles of stable address. With default parameters (13 and 4) `rspValid` rises 13 cycles after the accepting edge.
- R4: Each later item in the same page as its predecessor follows 4 cycles (the page wait) after the previous item.
- R5: When the previous item was the last one of its page (word offset bits [2:0] all ones, byte offset bits [3:0] all ones), the next item follows after the full random wait of 13 cycles.
- R6: Word mode (`reqByte`=0): `romWordSel` is 1, `romAddr` is the word address, addresses wrap modulo 2^ADDR_W, and `rspData` is the full 16-bit bus.
- R7: Byte mode (`reqByte`=1): `romWordSel` is 0, `romAddr` is byte address bits [ADDR_W:1], `romTopPinOut` carries byte address bit 0 with `romTopPinDrive` 1 while the chip is enabled, and `rspData` is data bits [7:0] with bits [15:8] zero.
- R8: A request with `reqLen`=N returns exactly N+1 items in increasing address order, each marked by a one-cycle `rspValid` pulse.
- R9: After the last item, `romCeN` and `romOeN` go to 1 at the capture edge, and `reqReady` returns 3 cycles (the float wait) after that edge.
- R10: The address lines change during a burst only at an edge that also captures an item.
- R11: During a burst `romCeN` stays 0 and `romWordSel` does not change until the last item has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqAddr | input | ADDR_W+1 | Start item address (word address in the low ADDR_W bits, or byte address) |
| reqLen | input | LEN_W | Number of items minus one |
| reqByte | input | 1 | 1 selects byte organisation, 0 selects word |
| rspValid | output | 1 | One-cycle strobe per returned item |
| rspData | output | DATA_W | Returned item, zero-extended in byte mode |
| romAddr | output | ADDR_W | ROM address bus |
| romCeN | output | 1 | Chip enable, active low |
| romOeN | output | 1 | Output enable, active low |
| romWordSel | output | 1 | Organisation select, 1 for word, 0 for byte |
| romDataIn | input | DATA_W | ROM data bus as seen by the controller |
| romTopPinOut | output | 1 | Lowest byte address bit, for the top data pin in byte mode |
| romTopPinDrive | output | 1 | Drive enable for the top data pin |

## Verification
The hardest case to reach from the ports is a page crossing in the middle of a burst. That crossing has to land on every possible page offset, in both organisations, and also at the point where the address wraps past the top of the ROM. The bench reaches it by sweeping the start address over the first twenty items and the last four items of the address space, in both modes, with burst lengths of 1, 4, 10 and 21 items. A behavioural ROM model is attached to the ports. It returns a poison pattern until the upper address, the in-page address and the output enable have each been stable for their full wait, so an early capture or a missing long wait shows up as wrong data as well as a wrong arrival cycle.

// File: rtl/prom_reader_pkg.sv
package prom_reader_pkg;

  // strobes from the sequencer to the address/data path
  typedef struct packed {
    logic load;     // take a new request
    logic step;     // advance to the next item
    logic capture;  // register the data bus
  } dpStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RECOVER = 2'd2
  } rdState_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/prom_reader_ctrl.sv
module prom_reader_ctrl
  import prom_reader_pkg::*;
#(
  parameter int RAND_CYC  = 13,
  parameter int PAGE_CYC  = 4,
  parameter int OE_CYC    = 4,
  parameter int FLOAT_CYC = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    lastItem,
  input  logic    pageCross,
  output logic    reqReady,
  output logic    romCeN,
  output logic    romOeN,
  output dpStrb_t strb
);

  localparam int RAND_C  = atLeastOne(RAND_CYC);
  localparam int PAGE_C  = atLeastOne(PAGE_CYC);
  localparam int OE_C    = atLeastOne(OE_CYC);
  localparam int FLOAT_C = atLeastOne(FLOAT_CYC);
  localparam int FIRST_C = (RAND_C > OE_C) ? RAND_C : OE_C;
  localparam int MAX_A   = (FIRST_C > PAGE_C) ? FIRST_C : PAGE_C;
  localparam int MAX_C   = (MAX_A > FLOAT_C) ? MAX_A : FLOAT_C;
  localparam int CNT_W   = $clog2(MAX_C + 1);

  rdState_t   state;
  logic [CNT_W-1:0] waitCnt;
  logic       accept;
  logic       lastWait;
  logic       ceNq;
  logic       oeNq;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign lastWait = (state == ST_ACCESS) && (waitCnt == '0);

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.capture = lastWait;
    strb.step    = lastWait && !lastItem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      ceNq    <= 1'b1;
      oeNq    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ACCESS;
            waitCnt <= CNT_W'(FIRST_C - 1);
            ceNq    <= 1'b0;
            oeNq    <= 1'b0;
          end
        end
        ST_ACCESS: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - CNT_W'(1);
          end else if (lastItem) begin
            state   <= ST_RECOVER;
            waitCnt <= CNT_W'(FLOAT_C - 1);
            ceNq    <= 1'b1;
            oeNq    <= 1'b1;
          end else if (pageCross) begin
            waitCnt <= CNT_W'(RAND_C - 1);
          end else begin
            waitCnt <= CNT_W'(PAGE_C - 1);
          end
        end
        ST_RECOVER: begin
          if (waitCnt == '0) begin
            state <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          ceNq  <= 1'b1;
          oeNq  <= 1'b1;
        end
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign romCeN   = ceNq;
  assign romOeN   = oeNq;

endmodule

// File: rtl/prom_reader_dp.sv
module prom_reader_dp
  import prom_reader_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqByte,
  input  logic [DATA_W-1:0] romDataIn,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romTopPin,
  output logic              byteMode,
  output logic              pageCross,
  output logic              lastItem,
  output logic [DATA_W-1:0] rspData,
  output logic              rspValid
);

  localparam int ITEM_W = ADDR_W + 1;
  localparam int BYTE_W = DATA_W / 2;

  logic [ITEM_W-1:0] curItem;
  logic [ITEM_W-1:0] nextItem;
  logic [LEN_W-1:0]  remain;
  logic              byteQ;

  // next item address: byte mode counts over ITEM_W bits, word mode over ADDR_W
  always_comb begin
    if (byteQ) begin
      nextItem = curItem + ITEM_W'(1);
    end else begin
      nextItem = {1'b0, curItem[ADDR_W-1:0] + ADDR_W'(1)};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curItem <= '0;
      remain  <= '0;
      byteQ   <= 1'b0;
    end else if (strb.load) begin
      byteQ   <= reqByte;
      remain  <= reqLen;
      curItem <= reqByte ? reqAddr : {1'b0, reqAddr[ADDR_W-1:0]};
    end else if (strb.step) begin
      curItem <= nextItem;
      remain  <= remain - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) begin
        if (byteQ) begin
          rspData <= {{(DATA_W-BYTE_W){1'b0}}, romDataIn[BYTE_W-1:0]};
        end else begin
          rspData <= romDataIn;
        end
      end
    end
  end

  // a page ends when every offset bit of the current item is one
  assign pageCross = byteQ ? (&curItem[PAGE_BITS:0]) : (&curItem[PAGE_BITS-1:0]);
  assign lastItem  = (remain == '0);
  assign romAddr   = byteQ ? curItem[ITEM_W-1:1] : curItem[ADDR_W-1:0];
  assign romTopPin = byteQ & curItem[0];
  assign byteMode  = byteQ;

endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_reader_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int LEN_W      = 8,
  parameter int DATA_W     = 16,
  parameter int PAGE_BITS  = 3,
  parameter int CLK_PS     = 8000,
  parameter int T_RAND_PS  = 100000,
  parameter int T_PAGE_PS  = 30000,
  parameter int T_OE_PS    = 30000,
  parameter int T_FLOAT_PS = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqByte,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romWordSel,
  input  logic [DATA_W-1:0] romDataIn,
  output logic              romTopPinOut,
  output logic              romTopPinDrive
);

  localparam int RAND_CYC  = ceilDiv(T_RAND_PS, CLK_PS);
  localparam int PAGE_CYC  = ceilDiv(T_PAGE_PS, CLK_PS);
  localparam int OE_CYC    = ceilDiv(T_OE_PS, CLK_PS);
  localparam int FLOAT_CYC = ceilDiv(T_FLOAT_PS, CLK_PS);

  dpStrb_t strb;
  logic    lastItem;
  logic    pageCross;
  logic    byteMode;

  prom_reader_ctrl #(
    .RAND_CYC (RAND_CYC),
    .PAGE_CYC (PAGE_CYC),
    .OE_CYC   (OE_CYC),
    .FLOAT_CYC(FLOAT_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lastItem (lastItem),
    .pageCross(pageCross),
    .reqReady (reqReady),
    .romCeN   (romCeN),
    .romOeN   (romOeN),
    .strb     (strb)
  );

  prom_reader_dp #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqByte  (reqByte),
    .romDataIn(romDataIn),
    .romAddr  (romAddr),
    .romTopPin(romTopPinOut),
    .byteMode (byteMode),
    .pageCross(pageCross),
    .lastItem (lastItem),
    .rspData  (rspData),
    .rspValid (rspValid)
  );

  assign romWordSel     = !byteMode;
  assign romTopPinDrive = byteMode && !romCeN;

endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romCeN,
  input logic              romOeN,
  input logic              romWordSel,
  input logic              romTopPinDrive
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (romCeN && romOeN && !rspValid)); // R1

  AST_ACCEPT_ONLY_READY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCeN) |-> ($past(reqValid) && $past(reqReady))); // R2

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !romCeN |-> !reqReady); // R2

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R8

  AST_RELEASE_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCeN) |-> !reqReady); // R9

  AST_ADDR_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN) && !$stable(romAddr)) |-> rspValid); // R10

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN)) |-> $stable(romWordSel)); // R11

  AST_TOP_PIN_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    romTopPinDrive |-> (!romWordSel && !romCeN)); // R7

endmodule

bind prom_page_reader prom_page_reader_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .rspValid      (rspValid),
  .romAddr       (romAddr),
  .romCeN        (romCeN),
  .romOeN        (romOeN),
  .romWordSel    (romWordSel),
  .romTopPinDrive(romTopPinDrive)
);

// File: tb/test_prom_page_reader.sv
module test_prom_page_reader;

  localparam int ADDR_W = 8;
  localparam int LEN_W  = 6;
  localparam int DATA_W = 16;
  // 125 MHz: 8 ns period; 100/30/30/20 ns rounded up to cycles
  localparam int RAND_W  = 13;
  localparam int PAGE_W  = 4;
  localparam int OE_W    = 4;
  localparam int FLOAT_W = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [ADDR_W:0]   reqAddr;
  logic [LEN_W-1:0]  reqLen;
  logic              reqByte;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic [ADDR_W-1:0] romAddr;
  logic              romCeN;
  logic              romOeN;
  logic              romWordSel;
  logic [DATA_W-1:0] romDataIn;
  logic              romTopPinOut;
  logic              romTopPinDrive;

  prom_page_reader #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) i_prom_page_reader (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqReady      (reqReady),
    .reqAddr       (reqAddr),
    .reqLen        (reqLen),
    .reqByte       (reqByte),
    .rspValid      (rspValid),
    .rspData       (rspData),
    .romAddr       (romAddr),
    .romCeN        (romCeN),
    .romOeN        (romOeN),
    .romWordSel    (romWordSel),
    .romDataIn     (romDataIn),
    .romTopPinOut  (romTopPinOut),
    .romTopPinDrive(romTopPinDrive)
  );

  int unsigned cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] wordVal(input logic [7:0] w);
    return {w ^ 8'hC3, w + 8'h11};
  endfunction

  // ---------------- behavioural ROM model ----------------
  logic [7:0] upCnt, lowCnt, oeCnt;
  logic [4:0] prevUp;
  logic [3:0] prevLow;
  logic       modelByte;
  logic       modelLsb;
  logic [4:0] curUp;
  logic [3:0] curLow;
  logic       modelOk;
  logic [15:0] wv;

  assign modelByte = !romWordSel;
  assign modelLsb  = modelByte && romTopPinDrive && romTopPinOut;
  assign curUp     = romAddr[7:3];
  assign curLow    = {romAddr[2:0], modelLsb};

  function automatic logic [7:0] satInc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  always @(negedge clk) begin
    prevUp  <= curUp;
    prevLow <= curLow;
    if (!rstN || romCeN) begin
      upCnt  <= 8'd0;
      lowCnt <= 8'd0;
    end else if (upCnt == 8'd0 || curUp != prevUp) begin
      upCnt  <= 8'd1;
      lowCnt <= 8'd1;
    end else begin
      upCnt  <= satInc(upCnt);
      lowCnt <= (curLow != prevLow) ? 8'd1 : satInc(lowCnt);
    end
    if (!rstN || romOeN || romCeN) oeCnt <= 8'd0;
    else oeCnt <= satInc(oeCnt);
  end

  always_comb begin
    modelOk = !romCeN && !romOeN && (upCnt >= 8'(RAND_W)) &&
              (lowCnt >= 8'(PAGE_W)) && (oeCnt >= 8'(OE_W));
    wv = wordVal(romAddr);
    if (!modelOk) romDataIn = 16'hEEEE;
    else if (modelByte) romDataIn = {1'b0, 7'h55, (modelLsb ? wv[15:8] : wv[7:0])};
    else romDataIn = wv;
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cycle);
    end
  endtask

  task automatic runBurst(input bit bm, input int start, input int len);
    int acc, expStamp, addr, lastStamp, extras, mask, guard, expA;
    bit crossed;
    logic [15:0] expD, w;
    mask = bm ? 511 : 255;
    @(negedge clk);
    guard = 0;
    while (!reqReady && guard < 500) begin @(negedge clk); guard++; end
    check(romCeN && romOeN, "R1 idle enables", {romCeN, romOeN}, 3);
    reqAddr  = start[ADDR_W:0];
    reqLen   = len[LEN_W-1:0];
    reqByte  = bm;
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    acc = cycle;
    reqValid = 1'b0;
    addr = start & mask;
    expA = bm ? (addr >> 1) : addr;
    check(!romCeN && !romOeN && !reqReady, "R2 bus opened", {romCeN, romOeN, reqReady}, 0);
    check(romAddr == expA[7:0], "R2 first address", romAddr, expA);
    expStamp = acc + RAND_W;
    lastStamp = acc;
    for (int k = 0; k <= len; k++) begin
      guard = 0;
      @(negedge clk);
      while (!rspValid && guard < 200) begin @(negedge clk); guard++; end
      if (k == 0) check(cycle == expStamp, "R3 first item arrival", cycle - acc, RAND_W);
      else if (crossed) check(cycle == expStamp, "R5 page crossing arrival", cycle - lastStamp, RAND_W);
      else check(cycle == expStamp, "R4 in-page arrival", cycle - lastStamp, PAGE_W);
      if (bm) begin
        w = wordVal(8'(addr >> 1));
        expD = {8'h00, (addr[0] ? w[15:8] : w[7:0])};
        check(rspData == expD, "R7 R10 byte data", rspData, expD);
        if (k == 0) check(romWordSel == 1'b0, "R7 select low", romWordSel, 0);
      end else begin
        expD = wordVal(8'(addr));
        check(rspData == expD, "R6 R10 word data", rspData, expD);
        if (k == 0) check(romWordSel == 1'b1, "R6 select high", romWordSel, 1);
      end
      if (k < len) check(!romCeN && romWordSel == !bm, "R11 chip held", {romCeN, romWordSel}, {1'b0, !bm});
      crossed = bm ? ((addr & 15) == 15) : ((addr & 7) == 7);
      addr = (addr + 1) & mask;
      lastStamp = cycle;
      expStamp = expStamp + (crossed ? RAND_W : PAGE_W);
    end
    check(romCeN && romOeN, "R9 enables released", {romCeN, romOeN}, 3);
    extras = 0;
    guard = 0;
    while (!reqReady && guard < 200) begin
      @(negedge clk);
      guard++;
      if (rspValid) extras++;
    end
    check(cycle == lastStamp + FLOAT_W, "R9 recovery gap", cycle - lastStamp, FLOAT_W);
    check(extras == 0, "R8 item count", extras, 0);
  endtask

  initial begin
    wait (cycle >= 150000);
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected below 150000", cycle);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lens[4];
    int start;
    lens = '{0, 3, 9, 20};
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = '0;
    reqLen = '0;
    reqByte = 1'b0;
    repeat (3) @(negedge clk);
    check(reqReady && romCeN && romOeN && !rspValid, "R1 reset state",
          {reqReady, romCeN, romOeN, rspValid}, 4'b1110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady && romCeN && romOeN && !rspValid && romWordSel, "R1 idle after reset",
          {reqReady, romCeN, romOeN, rspValid, romWordSel}, 5'b11101);
    for (int bm = 0; bm < 2; bm++) begin
      for (int i = 0; i < 24; i++) begin
        start = (i < 20) ? i : ((bm != 0 ? 512 : 256) - (24 - i));
        for (int l = 0; l < 4; l++) begin
          runBurst(bm[0], start, lens[l]);
        end
      end
    end
    repeat (5) @(negedge clk);
    check(reqReady && romCeN && !rspValid, "R1 final idle", {reqReady, romCeN, rspValid}, 3'b110);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule